// File: doc/BRIEF.md
# Host Memory Request to MI32 Master Bridge

This block is the master end of a 32-bit MI register bus. It accepts host memory requests that have already been decoded into a short descriptor and carries them out on the MI bus. The descriptor holds a window index, an address offset, a dword count, byte enables for the first and last dword, a write flag, a requester tag and a function number. The block maps the request into the MI address space by adding a per-window base address to the offset, after the offset has been cut to the usable number of low bits. It then performs one MI access per dword.

Write data arrives as a dword stream with its own valid/ready pair, one dword per MI write, and a write produces no completion. Read data coming back from the slave goes out as completion beats, one dword per beat. Each beat carries the tag, the function number, the bytes still to be returned and a flag that closes one completion. A completion never carries more than the configured maximum payload.

Only one request is handled at a time. A read that the slave never answers stalls the bridge for good, because the block has no read timeout.

Top module: `pcie_mi_bridge`

## Requirements
- R1: While reset is held and in the cycle after it, `reqReady` is 1 and `miRd`, `miWr`, `wdReady` and `cplValid` are 0.
- R2: The first MI address of a request is the base of the selected window plus the offset masked to its low `cfgAperture` bits, with address bits 1:0 forced to 0. Window codes 0 to 5 select the six BAR bases (defaults 0x01000000 to 0x06000000). Codes 6 and 7 select the expansion ROM base (default 0x0A000000). An aperture of 32 or more leaves the offset unmasked.
- R3: A request of N dwords produces exactly N MI accesses at addresses rising by 4. A length field of 0 means 1024 dwords.
- R4: The first access uses the first-dword byte enables, the final access uses the last-dword byte enables, and every access in between uses 4'hF. A single-dword request uses only the first-dword byte enables.
- R5: `miRd` or `miWr` stays high with the same address, byte enables and write data until a cycle with `miArdy` high. `miRd` and `miWr` are never high together.
- R6: Read data on `miDrd` is taken only in a cycle with `miDrdy` high, including the cycle in which the read is accepted. Until that happens no completion beat appears, with no time limit.
- R7: `miFunc` carries the function number of the request on every MI access that the request produces.
- R8: Each completion beat carries the request tag, the function number, the returned dword, and `cplByteCnt` equal to 4 times the number of dwords still owed, counting the current one. The beat is held unchanged until `cplReady` is high.
- R9: `cfgMaxPayload` codes 0, 1, 2 and 3 give 32, 64, 128 and 256 dwords per completion, and codes 4 to 7 act as code 3. `cplLast` is 1 on the beat that fills a completion to that limit and on the final beat of the request.
- R10: `reqReady` falls in the cycle after a request is accepted. It rises again in the cycle after the final write is acknowledged, or after the final completion beat is accepted.
- R11: For each MI write the block takes exactly one dword from the write stream (`wdValid` and `wdReady` both high). It drives that dword on `miDwr` and never raises `cplValid` for a write.
- R12: A synchronous reset in the middle of a read discards the held completion beat and returns the block to idle. The next request then completes with fresh data only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgAperture | input | 6 | Number of usable low offset bits |
| cfgMaxPayload | input | 3 | Encoded completion payload limit |
| reqValid | input | 1 | Request descriptor valid |
| reqReady | output | 1 | Bridge idle and able to take a request |
| reqBar | input | 3 | Window index (6 and 7: expansion ROM) |
| reqOffset | input | 32 | Byte offset inside the window |
| reqLen | input | 10 | Dword count, 0 means 1024 |
| reqFirstBe | input | 4 | Byte enables of the first dword |
| reqLastBe | input | 4 | Byte enables of the last dword |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqTag | input | 8 | Requester tag |
| reqFunc | input | 8 | Function number |
| wdValid | input | 1 | Write data dword valid |
| wdReady | output | 1 | Write data dword taken |
| wdData | input | 32 | Write data dword |
| miAddr | output | 32 | MI address |
| miDwr | output | 32 | MI write data |
| miBe | output | 4 | MI byte enables |
| miRd | output | 1 | MI read strobe |
| miWr | output | 1 | MI write strobe |
| miFunc | output | 8 | Function number of the current access |
| miArdy | input | 1 | Slave accepts the access |
| miDrd | input | 32 | Slave read data |
| miDrdy | input | 1 | Slave read data valid |
| cplValid | output | 1 | Completion beat valid |
| cplReady | input | 1 | Downstream takes the beat |
| cplTag | output | 8 | Tag of the completed request |
| cplFunc | output | 8 | Function number of the completed request |
| cplByteCnt | output | 13 | Bytes still owed, counting this beat |
| cplData | output | 32 | Returned dword |
| cplLast | output | 1 | Closes one completion |

## Verification
The assertions rely on a few properties of the inputs. The slave raises `miDrdy` only while a read is outstanding. The configuration inputs do not change while a request is being served. Downstream and slave ready signals may do anything. The bench meets these conditions with a slave model that returns data only for a read it has accepted, after a delay chosen per test (zero, short or several hundred cycles). It changes the aperture and payload settings only when the bridge is idle and every expected access and beat has been seen. Handshake pressure comes from a pseudo-random sequence that drives `miArdy` and `cplReady`.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  localparam int NUM_BASES = 7;
  localparam int AP_W      = 6;

  typedef struct packed {
    logic load;       // capture a new request descriptor
    logic wdTake;     // capture one write dword
    logic rdCapture;  // capture one read dword
    logic advance;    // one dword finished
  } pmbStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WDATA, ST_WRITE, ST_READ, ST_RWAIT, ST_CPL
  } pmbState_t;
endpackage

// File: rtl/pmb_ctrl.sv
module pmb_ctrl
  import pmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       wdValid,
  input  logic       miArdy,
  input  logic       miDrdy,
  input  logic       cplReady,
  input  logic       isLast,
  output logic       reqReady,
  output logic       wdReady,
  output logic       miRd,
  output logic       miWr,
  output logic       cplValid,
  output pmbStrobe_t stb
);
  pmbState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    stb      = '0;
    reqReady = 1'b0;
    wdReady  = 1'b0;
    miRd     = 1'b0;
    miWr     = 1'b0;
    cplValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.load = 1'b1;
          stateD   = reqWrite ? ST_WDATA : ST_READ;
        end
      end
      ST_WDATA: begin
        wdReady = 1'b1;
        if (wdValid) begin
          stb.wdTake = 1'b1;
          stateD     = ST_WRITE;
        end
      end
      ST_WRITE: begin
        miWr = 1'b1;
        if (miArdy) begin
          stb.advance = 1'b1;
          stateD      = isLast ? ST_IDLE : ST_WDATA;
        end
      end
      ST_READ: begin
        miRd = 1'b1;
        if (miArdy) begin
          if (miDrdy) begin
            stb.rdCapture = 1'b1;
            stateD        = ST_CPL;
          end else begin
            stateD = ST_RWAIT;
          end
        end
      end
      ST_RWAIT: begin
        if (miDrdy) begin
          stb.rdCapture = 1'b1;
          stateD        = ST_CPL;
        end
      end
      ST_CPL: begin
        cplValid = 1'b1;
        if (cplReady) begin
          stb.advance = 1'b1;
          stateD      = isLast ? ST_IDLE : ST_READ;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pmb_datapath.sv
module pmb_datapath
  import pmb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 10,
  parameter int TAG_W  = 8,
  parameter int FUNC_W = 8,
  parameter logic [NUM_BASES*ADDR_W-1:0] BASE_VEC = '0,
  localparam int BE_W    = DATA_W / 8,
  localparam int CNT_W   = LEN_W + 1,
  localparam int LOG_BE  = $clog2(BE_W),
  localparam int BCNT_W  = CNT_W + LOG_BE
)(
  input  logic              clk,
  input  logic              rst,
  input  pmbStrobe_t        stb,
  input  logic [AP_W-1:0]   cfgAperture,
  input  logic [2:0]        cfgMaxPayload,
  input  logic [2:0]        reqBar,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [BE_W-1:0]   reqFirstBe,
  input  logic [BE_W-1:0]   reqLastBe,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [DATA_W-1:0] wdData,
  input  logic [DATA_W-1:0] miDrd,
  output logic [ADDR_W-1:0] miAddr,
  output logic [DATA_W-1:0] miDwr,
  output logic [BE_W-1:0]   miBe,
  output logic [FUNC_W-1:0] miFunc,
  output logic [TAG_W-1:0]  cplTag,
  output logic [FUNC_W-1:0] cplFunc,
  output logic [BCNT_W-1:0] cplByteCnt,
  output logic [DATA_W-1:0] cplData,
  output logic              cplLast,
  output logic              isLast
);
  localparam int MIN_CHUNK = 128 / BE_W;

  logic [ADDR_W-1:0] baseArr [NUM_BASES];
  for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
    assign baseArr[g] = BASE_VEC[g*ADDR_W +: ADDR_W];
  end

  logic [2:0]        barIdx;
  logic [ADDR_W-1:0] apMask, startAddr;
  logic [CNT_W-1:0]  lenFull, chunkLimD;

  always_comb begin
    barIdx    = (reqBar > 3'd6) ? 3'd6 : reqBar;
    apMask    = (cfgAperture >= AP_W'(ADDR_W)) ? '1 : ~({ADDR_W{1'b1}} << cfgAperture);
    startAddr = (baseArr[barIdx] + (reqOffset & apMask)) & ~ADDR_W'(BE_W - 1);
    lenFull   = (reqLen == '0) ? CNT_W'(1 << LEN_W) : CNT_W'(reqLen);
    chunkLimD = CNT_W'(MIN_CHUNK) << (cfgMaxPayload[2] ? 2'd3 : cfgMaxPayload[1:0]);
  end

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  remainQ, chunkCntQ, chunkLimQ;
  logic              firstQ;
  logic [BE_W-1:0]   fbeQ, lbeQ;
  logic [TAG_W-1:0]  tagQ;
  logic [FUNC_W-1:0] funcQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              chunkEnd;

  assign isLast   = (remainQ == CNT_W'(1));
  assign chunkEnd = (chunkCntQ == chunkLimQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ     <= '0;
      remainQ   <= '0;
      chunkCntQ <= '0;
      chunkLimQ <= '0;
      firstQ    <= 1'b0;
      fbeQ      <= '0;
      lbeQ      <= '0;
      tagQ      <= '0;
      funcQ     <= '0;
      wdataQ    <= '0;
      rdataQ    <= '0;
    end else begin
      if (stb.load) begin
        addrQ     <= startAddr;
        remainQ   <= lenFull;
        chunkCntQ <= CNT_W'(1);
        chunkLimQ <= chunkLimD;
        firstQ    <= 1'b1;
        fbeQ      <= reqFirstBe;
        lbeQ      <= reqLastBe;
        tagQ      <= reqTag;
        funcQ     <= reqFunc;
      end
      if (stb.wdTake)    wdataQ <= wdData;
      if (stb.rdCapture) rdataQ <= miDrd;
      if (stb.advance) begin
        addrQ     <= addrQ + ADDR_W'(BE_W);
        remainQ   <= remainQ - CNT_W'(1);
        firstQ    <= 1'b0;
        chunkCntQ <= chunkEnd ? CNT_W'(1) : chunkCntQ + CNT_W'(1);
      end
    end
  end

  assign miAddr     = addrQ;
  assign miDwr      = wdataQ;
  assign miBe       = firstQ ? fbeQ : (isLast ? lbeQ : '1);
  assign miFunc     = funcQ;
  assign cplTag     = tagQ;
  assign cplFunc    = funcQ;
  assign cplByteCnt = {remainQ, {LOG_BE{1'b0}}};
  assign cplData    = rdataQ;
  assign cplLast    = isLast || chunkEnd;
endmodule

// File: rtl/pcie_mi_bridge.sv
module pcie_mi_bridge
  import pmb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 10,
  parameter int TAG_W  = 8,
  parameter int FUNC_W = 8,
  parameter logic [31:0] MI_BASE_B0  = 32'h0100_0000,
  parameter logic [31:0] MI_BASE_B1  = 32'h0200_0000,
  parameter logic [31:0] MI_BASE_B2  = 32'h0300_0000,
  parameter logic [31:0] MI_BASE_B3  = 32'h0400_0000,
  parameter logic [31:0] MI_BASE_B4  = 32'h0500_0000,
  parameter logic [31:0] MI_BASE_B5  = 32'h0600_0000,
  parameter logic [31:0] MI_BASE_ROM = 32'h0A00_0000,
  localparam int BE_W   = DATA_W / 8,
  localparam int BCNT_W = LEN_W + 1 + $clog2(BE_W)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [AP_W-1:0]   cfgAperture,
  input  logic [2:0]        cfgMaxPayload,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqBar,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [BE_W-1:0]   reqFirstBe,
  input  logic [BE_W-1:0]   reqLastBe,
  input  logic              reqWrite,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic              wdValid,
  output logic              wdReady,
  input  logic [DATA_W-1:0] wdData,
  output logic [ADDR_W-1:0] miAddr,
  output logic [DATA_W-1:0] miDwr,
  output logic [BE_W-1:0]   miBe,
  output logic              miRd,
  output logic              miWr,
  output logic [FUNC_W-1:0] miFunc,
  input  logic              miArdy,
  input  logic [DATA_W-1:0] miDrd,
  input  logic              miDrdy,
  output logic              cplValid,
  input  logic              cplReady,
  output logic [TAG_W-1:0]  cplTag,
  output logic [FUNC_W-1:0] cplFunc,
  output logic [BCNT_W-1:0] cplByteCnt,
  output logic [DATA_W-1:0] cplData,
  output logic              cplLast
);
  localparam logic [NUM_BASES*ADDR_W-1:0] BASE_VEC = {
    ADDR_W'(MI_BASE_ROM), ADDR_W'(MI_BASE_B5), ADDR_W'(MI_BASE_B4), ADDR_W'(MI_BASE_B3),
    ADDR_W'(MI_BASE_B2),  ADDR_W'(MI_BASE_B1), ADDR_W'(MI_BASE_B0)};

  pmbStrobe_t stb;
  logic       isLast;

  pmb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .wdValid(wdValid),
    .miArdy(miArdy), .miDrdy(miDrdy), .cplReady(cplReady), .isLast(isLast),
    .reqReady(reqReady), .wdReady(wdReady), .miRd(miRd), .miWr(miWr),
    .cplValid(cplValid), .stb(stb));

  pmb_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .FUNC_W(FUNC_W),
    .BASE_VEC(BASE_VEC)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .cfgAperture(cfgAperture), .cfgMaxPayload(cfgMaxPayload),
    .reqBar(reqBar), .reqOffset(reqOffset), .reqLen(reqLen), .reqFirstBe(reqFirstBe),
    .reqLastBe(reqLastBe), .reqTag(reqTag), .reqFunc(reqFunc), .wdData(wdData), .miDrd(miDrd),
    .miAddr(miAddr), .miDwr(miDwr), .miBe(miBe), .miFunc(miFunc), .cplTag(cplTag),
    .cplFunc(cplFunc), .cplByteCnt(cplByteCnt), .cplData(cplData), .cplLast(cplLast),
    .isLast(isLast));
endmodule

// File: rtl/pmb_checker.sv
module pmb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FUNC_W = 8,
  parameter int BCNT_W = 13,
  localparam int BE_W  = DATA_W / 8
)(
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              wdReady,
  input logic              miRd,
  input logic              miWr,
  input logic              miArdy,
  input logic [ADDR_W-1:0] miAddr,
  input logic [DATA_W-1:0] miDwr,
  input logic [BE_W-1:0]   miBe,
  input logic [FUNC_W-1:0] miFunc,
  input logic              cplValid,
  input logic              cplReady,
  input logic [DATA_W-1:0] cplData,
  input logic [BCNT_W-1:0] cplByteCnt,
  input logic              cplLast
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    miRd && !miArdy |=> miRd && $stable(miAddr) && $stable(miBe)); // R5

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    miWr && !miArdy |=> miWr && $stable(miAddr) && $stable(miBe) && $stable(miDwr)); // R5

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(miRd && miWr)); // R5

  AST_FUNC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (miRd || miWr) && !miArdy |=> $stable(miFunc)); // R7

  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (rst)
    cplValid && !cplReady |=> cplValid && $stable(cplData) && $stable(cplByteCnt)
                              && $stable(cplLast)); // R8

  AST_BUSY: assert property (@(posedge clk) disable iff (rst)
    (miRd || miWr || cplValid || wdReady) |-> !reqReady); // R10

  AST_NO_WRITE_CPL: assert property (@(posedge clk) disable iff (rst)
    (miWr || wdReady) |-> !cplValid); // R11
endmodule

bind pcie_mi_bridge pmb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FUNC_W(FUNC_W), .BCNT_W(BCNT_W)
) u_chk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .wdReady(wdReady), .miRd(miRd), .miWr(miWr),
  .miArdy(miArdy), .miAddr(miAddr), .miDwr(miDwr), .miBe(miBe), .miFunc(miFunc),
  .cplValid(cplValid), .cplReady(cplReady), .cplData(cplData), .cplByteCnt(cplByteCnt),
  .cplLast(cplLast));

// File: tb/sim_pcie_mi_bridge.sv
module sim_pcie_mi_bridge;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic [5:0]  cfgAperture = 6'd20;
  logic [2:0]  cfgMaxPayload = 3'd0;
  logic        reqValid = 1'b0, reqReady;
  logic [2:0]  reqBar = '0;
  logic [31:0] reqOffset = '0;
  logic [9:0]  reqLen = '0;
  logic [3:0]  reqFirstBe = '0, reqLastBe = '0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqTag = '0, reqFunc = '0;
  logic        wdValid = 1'b0, wdReady;
  logic [31:0] wdData = '0;
  logic [31:0] miAddr, miDwr;
  logic [3:0]  miBe;
  logic        miRd, miWr;
  logic [7:0]  miFunc;
  logic        miArdy = 1'b0;
  logic [31:0] miDrd = '0;
  logic        miDrdy = 1'b0;
  logic        cplValid, cplReady = 1'b0;
  logic [7:0]  cplTag, cplFunc;
  logic [12:0] cplByteCnt;
  logic [31:0] cplData;
  logic        cplLast;

  pcie_mi_bridge u0 (.*);

  typedef struct { logic [31:0] addr; logic [3:0] be; logic [31:0] data; logic [7:0] func;
                   bit wr; bit first; bit fin; } acc_t;
  typedef struct { logic [7:0] tag; logic [7:0] func; logic [12:0] bcnt; logic [31:0] data;
                   bit last; bit fin; } cpl_t;
  typedef struct { logic [2:0] bar; logic [31:0] off; logic [9:0] len; logic [3:0] fbe, lbe;
                   bit wr; logic [7:0] tag, func; } req_t;

  acc_t        accQ[$];
  cpl_t        cplQ[$];
  req_t        reqPQ[$];
  logic [31:0] wdQ[$];

  int nVec = 0, nBad = 0;
  bit busy = 0, done = 0, cplHold = 0, pend = 0;
  int pendCnt = 0, slaveDelay = 2;
  logic [31:0] pendAddr;
  logic [15:0] lfsr = 16'hACE1;
  bit prevRd = 0, prevWr = 0, prevCpl = 0, prevArdy = 0, prevCrdy = 0;
  logic [31:0] prevAddr, prevDwr, prevCData;
  logic [3:0]  prevBe;
  logic [12:0] prevBc;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] slv(input logic [31:0] a);
    return {a[15:0], ~a[31:16]};
  endfunction

  function automatic logic [31:0] baseOf(input logic [2:0] b);
    case (b)
      3'd0: return 32'h0100_0000;
      3'd1: return 32'h0200_0000;
      3'd2: return 32'h0300_0000;
      3'd3: return 32'h0400_0000;
      3'd4: return 32'h0500_0000;
      3'd5: return 32'h0600_0000;
      default: return 32'h0A00_0000;
    endcase
  endfunction

  task automatic enq(input logic [2:0] bar, input logic [31:0] off, input logic [9:0] len,
                     input logic [3:0] fbe, input logic [3:0] lbe, input bit wr,
                     input logic [7:0] tag, input logic [7:0] func);
    int n, lim;
    logic [31:0] m, a, ad;
    req_t r;
    n   = (len == 0) ? 1024 : int'(len);
    lim = (cfgMaxPayload > 3) ? 256 : (32 << cfgMaxPayload);
    m   = (cfgAperture >= 32) ? 32'hFFFF_FFFF : ((32'h1 << cfgAperture) - 1);
    a   = (baseOf(bar) + (off & m)) & 32'hFFFF_FFFC;
    for (int i = 0; i < n; i++) begin
      acc_t e;
      ad      = a + 32'(4 * i);
      e.addr  = ad;
      e.be    = (i == 0) ? fbe : ((i == n - 1) ? lbe : 4'hF);
      e.func  = func;
      e.wr    = wr;
      e.first = (i == 0);
      e.fin   = wr && (i == n - 1);
      e.data  = 32'hD000_0000 + {tag, 12'h0} + 32'(i);
      if (wr) wdQ.push_back(e.data);
      else begin
        cpl_t c;
        c.tag  = tag;
        c.func = func;
        c.bcnt = 13'(4 * (n - i));
        c.data = slv(ad);
        c.last = (i == n - 1) || (((i + 1) % lim) == 0);
        c.fin  = (i == n - 1);
        cplQ.push_back(c);
      end
      accQ.push_back(e);
    end
    r.bar = bar; r.off = off; r.len = len; r.fbe = fbe; r.lbe = lbe;
    r.wr = wr; r.tag = tag; r.func = func;
    reqPQ.push_back(r);
  endtask

  // cycle-by-cycle reference: drives the slave, sink and request side, compares every clock
  always @(negedge clk) begin
    if (rst || done) begin
      reqValid = 0; miArdy = 0; miDrdy = 0; cplReady = 0; wdValid = 0;
      pend = 0; prevRd = 0; prevWr = 0; prevCpl = 0;
    end else begin
      bit ardyN, crdyN;
      acc_t e;
      cpl_t c;
      req_t r;
      chk(reqReady == !busy, "R10 reqReady", 64'(reqReady), 64'(!busy));
      if (prevRd && !prevArdy)
        chk(miRd && miAddr == prevAddr && miBe == prevBe, "R5 read hold", {miRd, miAddr}, {1'b1, prevAddr});
      if (prevWr && !prevArdy)
        chk(miWr && miAddr == prevAddr && miBe == prevBe && miDwr == prevDwr, "R5 write hold",
            {miWr, miDwr}, {1'b1, prevDwr});
      if (prevCpl && !prevCrdy)
        chk(cplValid && cplData == prevCData && cplByteCnt == prevBc, "R8 beat hold",
            {cplValid, cplData}, {1'b1, prevCData});
      if (pend) chk(!cplValid, "R6 no beat before data", 64'(cplValid), 64'd0);

      lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ardyN = lfsr[0] | lfsr[3];
      crdyN = (lfsr[5] | lfsr[9]) && !cplHold;

      miDrdy = 0;
      miDrd  = 32'hDEAD_BEEF;
      if (pend) begin
        if (pendCnt == 0) begin miDrdy = 1; miDrd = slv(pendAddr); pend = 0; end
        else pendCnt--;
      end
      miArdy = ardyN;
      if ((miRd || miWr) && ardyN) begin
        if (accQ.size() == 0) chk(0, "R3 unexpected access", 64'(miAddr), 64'd0);
        else begin
          e = accQ.pop_front();
          chk(miAddr == e.addr, e.first ? "R2 start address" : "R3 address step", 64'(miAddr), 64'(e.addr));
          chk(miBe == e.be, "R4 byte enables", 64'(miBe), 64'(e.be));
          chk(miFunc == e.func, "R7 function", 64'(miFunc), 64'(e.func));
          chk(miWr == e.wr, "R11 access kind", 64'(miWr), 64'(e.wr));
          if (miWr) begin
            chk(miDwr == e.data, "R11 write data", 64'(miDwr), 64'(e.data));
            if (e.fin) busy = 0;
          end
        end
        if (miRd) begin
          if (slaveDelay == 0) begin miDrdy = 1; miDrd = slv(miAddr); end
          else begin pend = 1; pendCnt = slaveDelay - 1; pendAddr = miAddr; end
        end
      end

      cplReady = crdyN;
      if (cplValid && crdyN) begin
        if (cplQ.size() == 0) chk(0, "R11 unexpected beat", 64'(cplData), 64'd0);
        else begin
          c = cplQ.pop_front();
          chk(cplTag == c.tag && cplFunc == c.func, "R8 tag/function", {cplTag, cplFunc}, {c.tag, c.func});
          chk(cplByteCnt == c.bcnt, "R8 byte count", 64'(cplByteCnt), 64'(c.bcnt));
          chk(cplData == c.data, "R6 read data", 64'(cplData), 64'(c.data));
          chk(cplLast == c.last, "R9 last flag", 64'(cplLast), 64'(c.last));
          if (c.fin) busy = 0;
        end
      end

      wdValid = (wdQ.size() > 0);
      wdData  = wdValid ? wdQ[0] : 32'h0;
      if (wdValid && wdReady) void'(wdQ.pop_front());

      reqValid = 0;
      if (!busy && reqPQ.size() > 0) begin
        r = reqPQ.pop_front();
        reqValid = 1; reqBar = r.bar; reqOffset = r.off; reqLen = r.len;
        reqFirstBe = r.fbe; reqLastBe = r.lbe; reqWrite = r.wr; reqTag = r.tag; reqFunc = r.func;
        busy = 1;
      end

      prevRd = miRd; prevWr = miWr; prevCpl = cplValid; prevArdy = miArdy; prevCrdy = cplReady;
      prevAddr = miAddr; prevBe = miBe; prevDwr = miDwr; prevCData = cplData; prevBc = cplByteCnt;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic waitIdle();
    tick();
    while (busy || reqPQ.size() > 0 || accQ.size() > 0 || cplQ.size() > 0) tick();
    repeat (2) tick();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: state under reset
    chk(reqReady && !miRd && !miWr && !wdReady && !cplValid, "R1 reset outputs",
        {reqReady, miRd, miWr, wdReady, cplValid}, 5'b10000);
    rst = 0;
    tick();
    chk(reqReady && !miRd && !miWr && !wdReady && !cplValid, "R1 after reset",
        {reqReady, miRd, miWr, wdReady, cplValid}, 5'b10000);

    // R2 R4: single dword read, last enables ignored
    enq(3'd0, 32'h0000_0010, 10'd1, 4'h6, 4'hF, 0, 8'h03, 8'h11); waitIdle();
    // R3 R4 R11: three dword write
    enq(3'd2, 32'h0000_0100, 10'd3, 4'hE, 4'h3, 1, 8'h04, 8'h22); waitIdle();
    // R9: 40 dwords at 128-byte limit, last at 32 and 40
    enq(3'd1, 32'h0000_0200, 10'd40, 4'hF, 4'hF, 0, 8'h05, 8'h33); waitIdle();
    // R2: aperture masking, ROM codes 6 and 7
    cfgAperture = 6'd12;
    enq(3'd6, 32'hFFFF_F004, 10'd2, 4'hC, 4'h1, 0, 8'h06, 8'h44); waitIdle();
    enq(3'd7, 32'h1234_5678, 10'd1, 4'h3, 4'hF, 1, 8'h07, 8'h55); waitIdle();
    // R2: wide aperture, unaligned low bits dropped
    cfgAperture = 6'd40;
    enq(3'd5, 32'h0000_0123, 10'd2, 4'hF, 4'h7, 0, 8'h08, 8'h66); waitIdle();
    // R6: data in the acceptance cycle, then a very slow slave
    cfgAperture = 6'd20;
    slaveDelay = 0;
    enq(3'd3, 32'h0000_0040, 10'd3, 4'h8, 4'h1, 0, 8'h09, 8'h77); waitIdle();
    slaveDelay = 300;
    enq(3'd4, 32'h0000_0080, 10'd1, 4'hF, 4'hF, 0, 8'h0A, 8'h88); waitIdle();
    // R3 R9: length 0 is 1024 dwords, code 5 acts as 1024 bytes
    slaveDelay = 1;
    cfgMaxPayload = 3'd5;
    enq(3'd0, 32'h0000_1000, 10'd0, 4'hF, 4'hF, 0, 8'h0B, 8'h99); waitIdle();
    cfgMaxPayload = 3'd1;
    enq(3'd1, 32'h0000_0000, 10'd70, 4'h1, 4'h8, 0, 8'h0C, 8'hAA); waitIdle();
    // R4: single dword write uses the first enables only
    enq(3'd3, 32'h0000_0020, 10'd1, 4'h1, 4'hF, 1, 8'h0D, 8'hBB); waitIdle();

    // R12: reset while a beat is held
    cplHold = 1;
    enq(3'd2, 32'h0000_0300, 10'd4, 4'hF, 4'hF, 0, 8'h0E, 8'hCC);
    while (!cplValid) tick();
    repeat (3) tick();
    rst = 1;
    accQ.delete(); cplQ.delete(); reqPQ.delete(); wdQ.delete();
    busy = 0; cplHold = 0;
    repeat (2) tick();
    rst = 0;
    tick();
    chk(!cplValid && reqReady && !miRd, "R12 idle after reset", {cplValid, reqReady, miRd}, 3'b010);
    enq(3'd1, 32'h0000_0400, 10'd2, 4'hF, 4'hF, 0, 8'h0F, 8'hDD); waitIdle();

    done = 1;
    tick();
    summary();
    $finish;
  end
endmodule